// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It runs a repeating frame of three phases. During auto-zero the analog front end nulls its offsets. During integrate the unknown input is integrated for a fixed number of clocks. During deintegrate a reference of opposite sign ramps the integrator back toward zero, and a counter measures how long this takes. The block drives one select line per phase plus a reference-direction line to the analog switches. It samples a single comparator input and treats a change of that input as the zero crossing.

At the end of every deintegrate phase the count, the input sign and an overrange flag are captured into output registers, and a one-cycle done pulse is given. A run/hold input chooses between continuous conversion and conversion on demand. When the input is low, the conversion in progress is allowed to finish, and the sequencer then waits in auto-zero a short, fixed distance before the next integrate. When the input is high again, the next integrate follows after exactly that distance, so it always gets its full length.

The frame is 2^(CNT_W+1) clocks long and integrate takes 2^CNT_W of them. Deintegrate is cut off early enough that auto-zero always lasts at least AZ_MIN clocks.

Top module: `dsc_sequencer`

## Requirements
- R1: With run_i held high, int_o rises once every 2^(CNT_W+1) clocks and stays high for exactly 2^CNT_W clocks each time.
- R2: Exactly one of az_o, int_o, deint_o is high in every cycle. status_o is high when int_o or deint_o is high and low when az_o is high. status_o falls on the same edge that loads the result, so in the cycle where done_o is high, status_o is low.
- R3: The sign is taken from the synchronised comparator on the last integrate clock. pol_o is 1 for a positive input, which is an input that drives the comparator high while integrating. During deintegrate, ref_dn_o equals that sign: 1 selects the reference that pulls the integrator down.
- R4: The comparator input passes through SYNC_STAGES flip-flops. The latched count_o equals the number of deintegrate clocks that elapse before the raw comparator changes, minus one. The step that carries the integrator through zero is not counted.
- R5: A zero input gives count_o = 0 with ovr_o = 0, whatever state the comparator held before. pol_o then reports that held comparator state.
- R6: The largest valid reading is FS = 2^CNT_W - AZ_MIN - SYNC_STAGES - 2. If no crossing has been seen by then, ovr_o is 1 and count_o is all ones; at FS itself ovr_o is 0.
- R7: done_o is high for exactly one cycle per conversion. count_o, pol_o and ovr_o change only on the edge that raises done_o.
- R8: run_i is sampled in auto-zero, PARK_LEAD clocks before integrate would begin. If it is low there, the sequencer stays in auto-zero with int_o low. A conversion already under way when run_i falls still completes and reports its result.
- R9: From the park state, if run_i is driven high after some clock edge, int_o is high after the PARK_LEAD-th following edge. The next conversion then reads correctly.
- R10: After reset, az_o = 1, status_o = 0, done_o = 0, and count_o, pol_o, ovr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | 1 = convert continuously, 0 = finish and park |
| cmp_i | input | 1 | Raw comparator output from the analog section |
| az_o | output | 1 | Auto-zero switch select |
| int_o | output | 1 | Input-integrate switch select |
| deint_o | output | 1 | Reference-deintegrate switch select |
| ref_dn_o | output | 1 | During deintegrate, 1 = reference that drives the integrator down |
| status_o | output | 1 | High from integrate start until the result is latched |
| count_o | output | CNT_W | Latched reading |
| pol_o | output | 1 | Latched sign, 1 = positive |
| ovr_o | output | 1 | Latched overrange flag |
| done_o | output | 1 | One-cycle pulse when a new result is latched |

## Verification
The bench builds the block with CNT_W = 6, AZ_MIN = 16, PARK_LEAD = 7 and SYNC_STAGES = 2. This gives a 128-clock frame, a 64-clock integrate and a full-scale reading of 44. With these values several dozen conversions fit in a short run. Both sides of the overrange boundary, zero input after each comparator state, and the park-and-resume distance can all be reached directly. The integrator and comparator are modelled in the bench: integrate adds the input value each clock, deintegrate steps by 2^CNT_W, and the comparator holds its state when the integrator sits exactly at zero. A correct reading therefore equals the magnitude of the input value.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;

endpackage

// File: rtl/dsc_sync.sv
// Plain flip-flop chain for an asynchronous level; also used to release reset.
module dsc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dsc_ctrl.sv
// Phase sequencer: one frame counter times integrate, deintegrate and auto-zero.
module dsc_ctrl
  import dsc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int AZ_MIN      = 16,
  parameter int PARK_LEAD   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cmp_s_i,
  output phase_e           phase_o,
  output logic             sign_o,
  output logic             latch_o,
  output logic             ovr_o,
  output logic [CNT_W-1:0] reading_o
);

  localparam int FC_W  = CNT_W + 1;
  localparam int FRAME = 2 ** FC_W;
  localparam int NINT  = 2 ** CNT_W;
  localparam int DW    = NINT - AZ_MIN;
  localparam int LAT   = SYNC_STAGES + 1;

  localparam logic [FC_W-1:0]  PARK_POS   = FC_W'(FRAME - PARK_LEAD);
  localparam logic [FC_W-1:0]  FRAME_LAST = FC_W'(FRAME - 1);
  localparam logic [FC_W-1:0]  INT_LAST   = FC_W'(NINT - 1);
  localparam logic [FC_W-1:0]  DEINT_LAST = FC_W'(NINT + DW - 1);
  localparam logic [FC_W-1:0]  DEINT_BASE = FC_W'(NINT);
  localparam logic [CNT_W-1:0] LAT_V      = CNT_W'(LAT);

  phase_e           ph_q, ph_d;
  logic [FC_W-1:0]  fc_q, fc_d;
  logic             sign_q, sign_d;
  logic             stall;
  logic             fc_en;
  logic             crossed;
  logic [CNT_W-1:0] dcount;

  // Hold is honoured only at the park point inside auto-zero.
  assign stall   = (ph_q == PH_AZ) && (fc_q == PARK_POS) && !run_i;
  assign fc_en   = !stall;
  assign crossed = (ph_q == PH_DEINT) && (cmp_s_i != sign_q);
  assign dcount  = fc_q[CNT_W-1:0];

  always_comb begin
    ph_d    = ph_q;
    fc_d    = fc_q;
    sign_d  = sign_q;
    latch_o = 1'b0;
    ovr_o   = 1'b0;
    if (fc_en) begin
      fc_d = fc_q + FC_W'(1);
    end
    case (ph_q)
      PH_AZ: begin
        if (fc_en && (fc_q == FRAME_LAST)) begin
          ph_d = PH_INT;
        end
      end
      PH_INT: begin
        if (fc_q == INT_LAST) begin
          ph_d   = PH_DEINT;
          sign_d = cmp_s_i;
        end
      end
      PH_DEINT: begin
        if (crossed) begin
          latch_o = 1'b1;
          ph_d    = PH_AZ;
        end else if (fc_q == DEINT_LAST) begin
          latch_o = 1'b1;
          ovr_o   = 1'b1;
          ph_d    = PH_AZ;
        end
      end
      default: ph_d = PH_AZ;
    endcase
  end

  // Remove the synchroniser and overshoot latency; saturate at zero.
  always_comb begin
    if (dcount < LAT_V) begin
      reading_o = '0;
    end else begin
      reading_o = dcount - LAT_V;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_AZ;
      fc_q   <= PARK_POS;
      sign_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      fc_q   <= fc_d;
      sign_q <= sign_d;
    end
  end

  assign phase_o = ph_q;
  assign sign_o  = sign_q;

  // R1: integrate always begins at the start of the frame count
  p_int_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_INT && $past(ph_q) != PH_INT) |-> (fc_q == '0));

  // R6: deintegrate never runs past its window
  p_deint_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_DEINT) |-> (fc_q >= DEINT_BASE && fc_q <= DEINT_LAST));

  // R3: reference direction is frozen for the whole deintegrate phase
  p_ref_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_DEINT && $past(ph_q) == PH_DEINT) |-> $stable(sign_q));

  // R8: a low run/hold at the park point freezes the sequencer there
  p_hold_park_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> (ph_q == PH_AZ && fc_q == PARK_POS));

endmodule

// File: rtl/dsc_result.sv
// Output registers for one conversion result.
module dsc_result #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_i,
  input  logic             ovr_i,
  input  logic             sign_i,
  input  logic [CNT_W-1:0] reading_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pol_o,
  output logic             ovr_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pol_q, pol_d;
  logic             ovr_q, ovr_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    pol_d  = pol_q;
    ovr_d  = ovr_q;
    done_d = latch_i;
    if (latch_i) begin
      cnt_d = ovr_i ? {CNT_W{1'b1}} : reading_i;
      pol_d = sign_i;
      ovr_d = ovr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pol_q  <= 1'b0;
      ovr_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pol_q  <= pol_d;
      ovr_q  <= ovr_d;
      done_q <= done_d;
    end
  end

  assign count_o = cnt_q;
  assign pol_o   = pol_q;
  assign ovr_o   = ovr_q;
  assign done_o  = done_q;

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R7: results change only together with a done pulse
  p_result_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> ($stable(cnt_q) && $stable(pol_q) && $stable(ovr_q)));

  // R6: an overrange result always reads all ones
  p_ovr_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> (cnt_q == {CNT_W{1'b1}}));

endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
  import dsc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int AZ_MIN      = 16,
  parameter int PARK_LEAD   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cmp_i,
  output logic             az_o,
  output logic             int_o,
  output logic             deint_o,
  output logic             ref_dn_o,
  output logic             status_o,
  output logic [CNT_W-1:0] count_o,
  output logic             pol_o,
  output logic             ovr_o,
  output logic             done_o
);

  logic             rst_n;
  logic             cmp_s;
  phase_e           phase;
  logic             sign;
  logic             latch;
  logic             ovr_now;
  logic [CNT_W-1:0] reading;

  dsc_sync #(.STAGES(2), .RST_VAL(1'b0)) i_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .d_i     (1'b1),
    .q_o     (rst_n)
  );

  dsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_cmp_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_n),
    .d_i     (cmp_i),
    .q_o     (cmp_s)
  );

  dsc_ctrl #(
    .CNT_W       (CNT_W),
    .AZ_MIN      (AZ_MIN),
    .PARK_LEAD   (PARK_LEAD),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .run_i     (run_i),
    .cmp_s_i   (cmp_s),
    .phase_o   (phase),
    .sign_o    (sign),
    .latch_o   (latch),
    .ovr_o     (ovr_now),
    .reading_o (reading)
  );

  dsc_result #(.CNT_W(CNT_W)) i_result (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .latch_i   (latch),
    .ovr_i     (ovr_now),
    .sign_i    (sign),
    .reading_i (reading),
    .count_o   (count_o),
    .pol_o     (pol_o),
    .ovr_o     (ovr_o),
    .done_o    (done_o)
  );

  assign az_o     = (phase == PH_AZ);
  assign int_o    = (phase == PH_INT);
  assign deint_o  = (phase == PH_DEINT);
  assign ref_dn_o = (phase == PH_DEINT) && sign;
  assign status_o = (phase != PH_AZ);

  // R2: status drops exactly when the new result appears
  p_status_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> (!status_o && $past(status_o)));

  // R2: one phase select at a time
  p_phase_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot({az_o, int_o, deint_o}));

endmodule

// File: tb/test_dsc_sequencer.sv
module test_dsc_sequencer;

  localparam int W     = 6;
  localparam int AZM   = 16;
  localparam int PL    = 7;
  localparam int SS    = 2;
  localparam int N     = 1 << W;
  localparam int FRAME = 2 * N;
  localparam int FS    = N - AZM - SS - 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b1;
  logic         cmp = 1'b0;
  logic         az, intg, deint, ref_dn, status, pol, ovr, done;
  logic [W-1:0] count;

  int vin = 0;
  int integ = 0;
  int vn = 0;
  int n_chk = 0;
  int n_fail = 0;
  int phase_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dsc_sequencer #(
    .CNT_W(W), .AZ_MIN(AZM), .PARK_LEAD(PL), .SYNC_STAGES(SS)
  ) i_dsc_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cmp_i(cmp),
    .az_o(az), .int_o(intg), .deint_o(deint), .ref_dn_o(ref_dn),
    .status_o(status), .count_o(count), .pol_o(pol), .ovr_o(ovr),
    .done_o(done)
  );

  // Integrator and comparator model; the comparator holds at exactly zero.
  always @(posedge clk) begin
    vn = integ;
    if (az) vn = 0;
    else if (intg) vn = integ + vin;
    else if (deint) vn = ref_dn ? integ - N : integ + N;
    integ <= vn;
    if (vn > 0) cmp <= 1'b1;
    else if (vn < 0) cmp <= 1'b0;
  end

  // R2 phase and status consistency, observed every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if ((32'(az) + 32'(intg) + 32'(deint)) != 1) phase_bad++;
      if (status != (intg || deint)) phase_bad++;
    end
  end

  function automatic int mag(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic bit exp_ovr(int x);
    return mag(x) > FS;
  endfunction

  function automatic int exp_cnt(int x);
    return exp_ovr(x) ? (N - 1) : mag(x);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Wait for done; R7: results must not move before it.
  task automatic wait_done(output bit ok);
    logic [W-1:0] c0;
    logic         p0, o0;
    bit           moved;
    c0 = count; p0 = pol; o0 = ovr; moved = 1'b0; ok = 1'b0;
    for (int i = 0; i < 4 * FRAME; i++) begin
      @(negedge clk);
      if (done) begin
        ok = 1'b1;
        break;
      end
      if (count != c0 || pol != p0 || ovr != o0) moved = 1'b1;
    end
    check(ok, "R7", "done pulse seen", int'(ok), 1);
    check(!moved, "R7", "result steady before done", int'(moved), 0);
  endtask

  task automatic conv(int x, string req);
    bit ok;
    bit prior;
    vin = x;
    prior = cmp;
    wait_done(ok);
    if (ok) begin
      check(count == W'(exp_cnt(x)), req, $sformatf("count for %0d", x), int'(count), exp_cnt(x));
      check(ovr == exp_ovr(x), req, $sformatf("ovr for %0d", x), int'(ovr), int'(exp_ovr(x)));
      if (x != 0) check(pol == (x > 0), "R3", $sformatf("pol for %0d", x), int'(pol), int'(x > 0));
      else check(pol == prior, "R5", "pol for zero", int'(pol), int'(prior));
      check(!status, "R2", "status low with done", int'(status), 0);
      @(negedge clk);
      check(!done, "R7", "done single cycle", int'(done), 0);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    bit ok;
    int t;
    int x;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(az, "R10", "az after reset", int'(az), 1);
    check(!status, "R10", "status after reset", int'(status), 0);
    check(!done, "R10", "done after reset", int'(done), 0);
    check(count == '0, "R10", "count after reset", int'(count), 0);
    check(!pol && !ovr, "R10", "pol/ovr after reset", int'({pol, ovr}), 0);

    // directed corners: R4 small, R5 zero after each comparator state, R6 boundary
    conv(1, "R4");
    conv(-1, "R4");
    conv(0, "R5");
    conv(7, "R4");
    conv(0, "R5");
    conv(FS, "R6");
    conv(-FS, "R6");
    conv(FS + 1, "R6");
    conv(-(FS + 1), "R6");
    conv(N - 3, "R6");

    // R1 frame and integrate length
    vin = 5;
    while (!intg) @(negedge clk);
    t = 0;
    while (intg) begin @(negedge clk); t++; end
    check(t == N, "R1", "integrate length", t, N);
    while (!intg) begin @(negedge clk); t++; end
    check(t == FRAME, "R1", "frame period", t, FRAME);
    wait_done(ok);

    // random conversions
    for (int i = 0; i < 40; i++) begin
      x = int'($urandom_range(2 * (FS + 3))) - (FS + 3);
      conv(x, "R4");
    end

    // R8 hold during a conversion, then R9 resume
    vin = -12;
    while (!intg) @(negedge clk);
    run = 1'b0;
    conv(-12, "R8");
    t = 0;
    for (int i = 0; i < 3 * FRAME; i++) begin
      @(negedge clk);
      if (intg || !az) t++;
    end
    check(t == 0, "R8", "parked cycles outside auto-zero", t, 0);
    run = 1'b1;
    t = 0;
    for (int i = 1; i <= FRAME; i++) begin
      @(negedge clk);
      if (intg) begin t = i; break; end
    end
    check(t == PL, "R9", "clocks from resume to integrate", t, PL);
    conv(-12, "R9");

    // R8 hold requested during auto-zero, then R9 resume
    run = 1'b0;
    t = 0;
    for (int i = 0; i < 2 * FRAME; i++) begin
      @(negedge clk);
      if (intg) t++;
    end
    check(t == 0, "R8", "no integrate while held", t, 0);
    vin = 33;
    run = 1'b1;
    t = 0;
    for (int i = 1; i <= FRAME; i++) begin
      @(negedge clk);
      if (intg) begin t = i; break; end
    end
    check(t == PL, "R9", "clocks from resume to integrate", t, PL);
    conv(33, "R9");

    check(phase_bad == 0, "R2", "phase/status mismatches", phase_bad, 0);
    finish_run();
  end

endmodule